// File: doc/BRIEF.md
# Outbound Address Window Translator

This block turns an outbound bus address into the address a PCIe transaction should carry, and picks the transaction attributes for it. It holds a set of programmable windows. Each window has a match value, a remap value and a mask, all 64 bits, plus a 32-bit action word. An address that lands inside an enabled window is rebased onto that window's remap value and takes that window's action. An address that lands in no window passes through unchanged and takes a separate default action word. Left at its reset value, that default asks for plain memory access, so the whole address space is a transparent memory path until software sets up windows.

The lookup is combinational from the request address to the outputs. A one-word write port programs the registers, and a write changes the outputs from the cycle after its clock edge. A global enable input turns the whole translation off, and the request then passes through with no action selected. Building packets from the chosen action is left to the logic that follows this block.

Top module: `oawt_xlat`

## Requirements
- R1: After reset every window is disabled and the default action word is zero. An enabled lookup of any address then reports default with type 0x0 (memory), and the output address equals the input address.
- R2: The write port uses byte offsets. Window i starts at i*0x20. Within a window, offset 0x00 is match[31:0], 0x04 is match[63:32], 0x08 is remap[31:0], 0x0C is remap[63:32], 0x10 is mask[31:0], 0x14 is mask[63:32] and 0x18 is the action word. The default action word is at offset 0xFC. A write to any other offset has no effect on any output.
- R3: Window i hits when match[0] is 1 and (addr & mask) == (match & mask). Mask bits 15:0 are always treated as zero, whatever value was written to them.
- R4: On a hit, the output address is (remap & mask) | (addr & ~mask). Remap bits outside the mask have no effect.
- R5: When several windows hit, the one with the lowest index is selected, and its index is reported on out_win.
- R6: The selected action word is split into fields as follows: type in bits 3:0 (memory 0x0, I/O 0x4, config type 0 0x8, config type 1 0x9, message 0xC), ID-ordering in bit 4, poison in bit 5, no-snoop in bit 6, relaxed ordering in bit 7, traffic class in bits 10:8, and attribute enable in bit 11.
- R7: With translation enabled and no hit, out_dflt is 1, out_hit is 0, the output address equals the input address, and the action fields come from the default word.
- R8: With translation disabled, the output address equals the input address, out_hit and out_dflt are 0, and every action field is 0.
- R9: A window whose match[0] is 0 never hits, even when its mask would match the address.
- R10: A register write shows no effect on the outputs before the rising edge that captures it, and shows its full effect right after that edge.
- R11: When there is no hit, out_win is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| xlat_en | input | 1 | Global translation enable |
| req_addr | input | 64 | Outbound request address |
| out_addr | output | 64 | Translated address |
| out_hit | output | 1 | A window was selected |
| out_dflt | output | 1 | Default action was selected |
| out_win | output | 3 | Index of the selected window |
| out_type | output | 4 | Transaction type field |
| out_tc | output | 3 | Traffic class field |
| out_attr_en | output | 1 | Attribute enable field |
| out_relaxed | output | 1 | Relaxed ordering flag |
| out_nosnoop | output | 1 | No-snoop flag |
| out_poison | output | 1 | Poison flag |
| out_ido | output | 1 | ID-ordering flag |

## Verification
The hardest case to reach from the ports is an address that two or more enabled windows claim at once. Priority only shows when the overlap exists and the lower-numbered window really is the one reported. To get there, the stimulus programs a narrow window at index 2 inside a wide window at index 5. It then enables a catch-all window at index 1 whose mask is zero, so it claims every address. Along the way it probes addresses inside both windows, inside only the wide one and outside both. The catch-all window is first written with its enable bit clear, to show that a matching mask alone does not make a hit. Every write is checked just before and just after its capturing edge.

// File: rtl/oawt_pkg.sv
package oawt_pkg;

  localparam int WORD_W = 32;

  localparam logic [3:0] KIND_MEM  = 4'h0;
  localparam logic [3:0] KIND_IO   = 4'h4;
  localparam logic [3:0] KIND_CFG0 = 4'h8;
  localparam logic [3:0] KIND_CFG1 = 4'h9;
  localparam logic [3:0] KIND_MSG  = 4'hC;

  typedef struct packed {
    logic       attr_en;
    logic [2:0] tc;
    logic       relaxed;
    logic       nosnoop;
    logic       poison;
    logic       ido;
    logic [3:0] kind;
  } act_t;

  function automatic act_t split_action(input logic [WORD_W-1:0] w);
    act_t f;
    f.kind    = w[3:0];
    f.ido     = w[4];
    f.poison  = w[5];
    f.nosnoop = w[6];
    f.relaxed = w[7];
    f.tc      = w[10:8];
    f.attr_en = w[11];
    return f;
  endfunction

endpackage

// File: rtl/oawt_regs.sv
module oawt_regs #(
  parameter int NWIN      = 8,
  parameter int AW        = 64,
  parameter int MIN_SHIFT = 16,
  parameter int CAW       = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [CAW-1:0]                    waddr,
  input  logic [oawt_pkg::WORD_W-1:0]       wdata,
  output logic [NWIN-1:0][AW-1:0]           match_q,
  output logic [NWIN-1:0][AW-1:0]           remap_q,
  output logic [NWIN-1:0][AW-1:0]           mask_q,
  output logic [NWIN-1:0][oawt_pkg::WORD_W-1:0] act_q,
  output logic [oawt_pkg::WORD_W-1:0]       dflt_q
);
  localparam int DW     = oawt_pkg::WORD_W;
  localparam int WIN_SH = 5;
  localparam int IW     = CAW - WIN_SH;
  localparam logic [CAW-1:0] DFLT_OFF = CAW'((NWIN - 1) * 32 + 28);
  localparam logic [DW-1:0]  LOW_CLR  = ~DW'((64'd1 << MIN_SHIFT) - 64'd1);

  logic [WIN_SH-1:0] off;
  logic [IW-1:0]     sel_idx;
  assign off     = waddr[WIN_SH-1:0];
  assign sel_idx = waddr[CAW-1:WIN_SH];

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    logic [AW-1:0] m_r, r_r, k_r;
    logic [DW-1:0] a_r;
    logic          sel;
    assign sel = we && (sel_idx == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_r <= '0;
        r_r <= '0;
        k_r <= '0;
        a_r <= '0;
      end else if (sel) begin
        case (off)
          5'h00: m_r[DW-1:0]  <= wdata;
          5'h04: m_r[AW-1:DW] <= wdata[AW-DW-1:0];
          5'h08: r_r[DW-1:0]  <= wdata;
          5'h0C: r_r[AW-1:DW] <= wdata[AW-DW-1:0];
          5'h10: k_r[DW-1:0]  <= wdata & LOW_CLR;
          5'h14: k_r[AW-1:DW] <= wdata[AW-DW-1:0];
          5'h18: a_r          <= wdata;
          default: ;
        endcase
      end
    end

    assign match_q[i] = m_r;
    assign remap_q[i] = r_r;
    assign mask_q[i]  = k_r;
    assign act_q[i]   = a_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         dflt_q <= '0;
    else if (we && waddr == DFLT_OFF)   dflt_q <= wdata;
  end

endmodule

// File: rtl/oawt_lookup.sv
module oawt_lookup #(
  parameter  int NWIN = 8,
  parameter  int AW   = 64,
  localparam int WW   = $clog2(NWIN)
) (
  input  logic [AW-1:0]           addr,
  input  logic [NWIN-1:0][AW-1:0] match_q,
  input  logic [NWIN-1:0][AW-1:0] remap_q,
  input  logic [NWIN-1:0][AW-1:0] mask_q,
  output logic [NWIN-1:0]         hit_vec,
  output logic                    any_hit,
  output logic [WW-1:0]           win_idx,
  output logic [AW-1:0]           xaddr
);

  function automatic logic f_claims(input logic [AW-1:0] a, m, k);
    return m[0] && ((a & k) == (m & k));
  endfunction

  function automatic logic [AW-1:0] f_rebase(input logic [AW-1:0] a, r, k);
    return (r & k) | (a & ~k);
  endfunction

  for (genvar i = 0; i < NWIN; i++) begin : g_cmp
    assign hit_vec[i] = f_claims(addr, match_q[i], mask_q[i]);
  end

  always_comb begin
    win_idx = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) win_idx = WW'(i);
    end
  end

  assign any_hit = |hit_vec;
  assign xaddr   = f_rebase(addr, remap_q[win_idx], mask_q[win_idx]);

endmodule

// File: rtl/oawt_xlat.sv
module oawt_xlat #(
  parameter  int NWIN      = 8,
  parameter  int AW        = 64,
  parameter  int MIN_SHIFT = 16,
  localparam int WW        = $clog2(NWIN),
  localparam int CAW       = WW + 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [31:0]    cfg_wdata,
  input  logic           xlat_en,
  input  logic [AW-1:0]  req_addr,
  output logic [AW-1:0]  out_addr,
  output logic           out_hit,
  output logic           out_dflt,
  output logic [WW-1:0]  out_win,
  output logic [3:0]     out_type,
  output logic [2:0]     out_tc,
  output logic           out_attr_en,
  output logic           out_relaxed,
  output logic           out_nosnoop,
  output logic           out_poison,
  output logic           out_ido
);
  import oawt_pkg::*;

  logic [NWIN-1:0][AW-1:0]   match_q, remap_q, mask_q;
  logic [NWIN-1:0][WORD_W-1:0] act_q;
  logic [WORD_W-1:0]         dflt_q;
  logic [NWIN-1:0]           hit_vec;
  logic                      any_hit;
  logic [WW-1:0]             win_idx;
  logic [AW-1:0]             xaddr;
  act_t                      sel_act;

  oawt_regs #(.NWIN(NWIN), .AW(AW), .MIN_SHIFT(MIN_SHIFT), .CAW(CAW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .match_q(match_q), .remap_q(remap_q), .mask_q(mask_q),
    .act_q(act_q), .dflt_q(dflt_q)
  );

  oawt_lookup #(.NWIN(NWIN), .AW(AW)) u_lookup (
    .addr(req_addr), .match_q(match_q), .remap_q(remap_q), .mask_q(mask_q),
    .hit_vec(hit_vec), .any_hit(any_hit), .win_idx(win_idx), .xaddr(xaddr)
  );

  always_comb begin
    if (!xlat_en)     sel_act = '0;
    else if (any_hit) sel_act = split_action(act_q[win_idx]);
    else              sel_act = split_action(dflt_q);
  end

  assign out_hit     = xlat_en && any_hit;
  assign out_dflt    = xlat_en && !any_hit;
  assign out_win     = out_hit ? win_idx : '0;
  assign out_addr    = out_hit ? xaddr : req_addr;
  assign out_type    = sel_act.kind;
  assign out_tc      = sel_act.tc;
  assign out_attr_en = sel_act.attr_en;
  assign out_relaxed = sel_act.relaxed;
  assign out_nosnoop = sel_act.nosnoop;
  assign out_poison  = sel_act.poison;
  assign out_ido     = sel_act.ido;

endmodule

// File: rtl/oawt_xlat_chk.sv
module oawt_xlat_chk #(
  parameter  int NWIN      = 8,
  parameter  int AW        = 64,
  parameter  int MIN_SHIFT = 16,
  localparam int WW        = $clog2(NWIN)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xlat_en,
  input logic [AW-1:0]   req_addr,
  input logic [AW-1:0]   out_addr,
  input logic            out_hit,
  input logic            out_dflt,
  input logic [WW-1:0]   out_win,
  input logic [3:0]      out_type,
  input logic [2:0]      out_tc,
  input logic [NWIN-1:0] hit_vec
);

  a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !xlat_en |-> (out_addr == req_addr) && !out_hit && !out_dflt &&
                 (out_type == 4'h0) && (out_tc == 3'd0));

  a_r7_miss_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_en && !out_hit) |-> out_dflt && (out_addr == req_addr));

  a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> hit_vec[out_win] &&
                ((hit_vec & ~({NWIN{1'b1}} << out_win)) == '0));

  a_r3_hit_tracks_compare: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_en |-> (out_hit == (hit_vec != '0)));

  a_r4_page_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    out_addr[MIN_SHIFT-1:0] == req_addr[MIN_SHIFT-1:0]);

  a_r11_idle_index: assert property (@(posedge clk) disable iff (!rst_n)
    !out_hit |-> (out_win == '0));

endmodule

bind oawt_xlat oawt_xlat_chk #(.NWIN(NWIN), .AW(AW), .MIN_SHIFT(MIN_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .req_addr(req_addr),
  .out_addr(out_addr), .out_hit(out_hit), .out_dflt(out_dflt), .out_win(out_win),
  .out_type(out_type), .out_tc(out_tc), .hit_vec(hit_vec)
);

// File: tb/oawt_xlat_bench.sv
module oawt_xlat_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        xlat_en = 0;
  logic [63:0] req_addr = '0;
  logic [63:0] out_addr;
  logic        out_hit, out_dflt;
  logic [2:0]  out_win;
  logic [3:0]  out_type;
  logic [2:0]  out_tc;
  logic        out_attr_en, out_relaxed, out_nosnoop, out_poison, out_ido;

  int vectors = 0;
  int misses = 0;
  bit done = 0;

  logic [63:0] sm [NW];
  logic [63:0] sr [NW];
  logic [63:0] sk [NW];
  logic [31:0] sa [NW];
  logic [31:0] sd;

  always #(CLK_PERIOD/2) clk = ~clk;

  oawt_xlat u_oawt_xlat (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .xlat_en(xlat_en), .req_addr(req_addr),
    .out_addr(out_addr), .out_hit(out_hit), .out_dflt(out_dflt), .out_win(out_win),
    .out_type(out_type), .out_tc(out_tc), .out_attr_en(out_attr_en),
    .out_relaxed(out_relaxed), .out_nosnoop(out_nosnoop), .out_poison(out_poison),
    .out_ido(out_ido)
  );

  task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [63:0] ea;
    logic        eh, ed;
    logic [2:0]  ew;
    logic [31:0] word;
    logic [11:0] ef, af;
    ea = req_addr; eh = 0; ed = 0; ew = 0; word = 0;
    if (xlat_en) begin
      for (int i = NW - 1; i >= 0; i--) begin
        if (sm[i][0] && ((req_addr & sk[i]) == (sm[i] & sk[i]))) begin
          eh = 1; ew = 3'(i);
        end
      end
      if (eh) begin
        ea = (sr[ew] & sk[ew]) | (req_addr & ~sk[ew]);
        word = sa[ew];
      end else begin
        ed = 1; word = sd;
      end
    end
    ef = word[11:0];
    af = {out_attr_en, out_tc, out_relaxed, out_nosnoop, out_poison, out_ido, out_type};
    cmp(req, "addr", out_addr, ea);
    cmp(req, "hit", 64'(out_hit), 64'(eh));
    cmp(req, "dflt", 64'(out_dflt), 64'(ed));
    cmp(req, "win", 64'(out_win), 64'(ew));
    cmp(req, "fields", 64'(af), 64'(ef));
  endtask

  task automatic probe(input logic [63:0] a, input logic en, input string req);
    @(negedge clk);
    req_addr = a;
    xlat_en = en;
    #1;
    check_all(req);
  endtask

  // R10: state seen just before and just after the capturing edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    int idx;
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    #1;
    check_all("R10 before edge");
    @(posedge clk);
    idx = int'(a[7:5]);
    if (a == 8'hFC) sd = d;
    else case (a[4:0])
      5'h00: sm[idx][31:0]  = d;
      5'h04: sm[idx][63:32] = d;
      5'h08: sr[idx][31:0]  = d;
      5'h0C: sr[idx][63:32] = d;
      5'h10: sk[idx][31:0]  = d & 32'hFFFF_0000;
      5'h14: sk[idx][63:32] = d;
      5'h18: sa[idx]        = d;
      default: ;
    endcase
    #1;
    cfg_we = 0;
    check_all("R10 after edge");
  endtask

  task automatic wr64(input int win, input logic [4:0] off, input logic [63:0] v);
    wr(8'(win * 32) + 8'(off) + 8'h4, v[63:32]);
    wr(8'(win * 32) + 8'(off), v[31:0]);
  endtask

  task automatic t_reset;
    probe(64'h0123_4567_89AB_CDEF, 1, "R1 reset default");
    probe(64'hFFFF_FFFF_FFFF_FFFF, 1, "R1 reset top address");
    vectors++;
    if (!(out_dflt && out_type == 4'h0)) begin
      misses++;
      $display("FAIL R1 reset type: actual %h expected 0", out_type);
    end
  endtask

  task automatic t_single;
    wr64(2, 5'h10, 64'hFFFF_FFFF_FFF0_FFFF);
    wr64(2, 5'h08, 64'h0000_00AB_C000_1234);
    wr(8'h58, 32'h0000_0D94);
    wr64(2, 5'h00, 64'h0000_0001_2340_0001);
    probe(64'h0000_0001_2345_6789, 1, "R4 rebase in window 2");
    vectors++;
    if (out_addr !== 64'h0000_00AB_C005_6789 || out_type !== 4'h4) begin
      misses++;
      $display("FAIL R4 literal: actual %h expected %h", out_addr, 64'h0000_00AB_C005_6789);
    end
    probe(64'h0000_0001_2340_0000, 1, "R3 lower edge");
    probe(64'h0000_0001_234F_FFFF, 1, "R3 upper edge");
    probe(64'h0000_0001_2350_0000, 1, "R3 just above");
    probe(64'h0000_0003_2345_6789, 1, "R3 high word differs");
  endtask

  task automatic t_overlap;
    wr64(5, 5'h10, 64'hFFFF_FFFF_0000_0000);
    wr(8'hB8, 32'h0000_0068);
    wr64(5, 5'h00, 64'h0000_0001_0000_0001);
    probe(64'h0000_0001_2345_6789, 1, "R5 overlap picks 2");
    probe(64'h0000_0001_8000_0010, 1, "R6 window 5 fields");
    probe(64'h0000_0002_0000_0000, 1, "R7 outside both");
  endtask

  task automatic t_enable_bit;
    wr(8'h38, 32'h0000_000C);
    wr(8'h24, 32'h0000_0005);
    probe(64'h0000_0009_0000_0000, 1, "R9 disabled catch-all");
    probe(64'h0000_0001_2345_6789, 1, "R9 disabled leaves window 2");
    wr(8'h20, 32'h0000_0001);
    probe(64'h0000_0001_2345_6789, 1, "R5 catch-all wins");
    probe(64'h0000_0009_0000_0000, 1, "R5 catch-all anywhere");
    wr(8'h20, 32'h0000_0000);
    probe(64'h0000_0001_8000_0010, 1, "R9 catch-all off again");
  endtask

  task automatic t_default;
    wr(8'hFC, 32'h0000_0AF9);
    probe(64'h0000_0002_0000_0000, 1, "R7 default word fields");
    probe(64'h8000_0000_0000_0042, 1, "R7 default passthrough");
    probe(64'h0000_0001_2345_6789, 1, "R6 hit ignores default");
  endtask

  task automatic t_ignored;
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h12, 32'h0000_0000);
    probe(64'h0000_0001_2345_6789, 1, "R2 stray offsets ignored");
    probe(64'h0000_0002_0000_0000, 1, "R2 default unchanged");
  endtask

  task automatic t_disabled;
    probe(64'h0000_0001_2345_6789, 0, "R8 off in window");
    probe(64'h0000_0002_0000_0000, 0, "R8 off outside");
    probe(64'h0000_0001_2345_6789, 1, "R8 back on");
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin
      sm[i] = '0; sr[i] = '0; sk[i] = '0; sa[i] = '0;
    end
    sd = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_single;
    t_overlap;
    t_enable_bit;
    t_default;
    t_ignored;
    t_disabled;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule